// File: doc/BRIEF.md
# Timer Pin Edge Qualifier

This block conditions one external input pin of a 16-bit timer/event counter. The asynchronous pin first goes through a flop synchronizer. A sample filter then accepts a new level only after that level has been seen on a number of consecutive sampling strobes. The edge stage compares the filtered level with a remembered previous level and raises a one-cycle strobe for each edge that matches the programmed edge selection.

The strobe is routed by a mode input. In count mode it drives the counter's count enable, and the filter samples on every system clock. In capture mode it drives the capture trigger, and the filter samples only on a prescaled strobe that comes from outside the block. The counter, the compare registers and the capture registers sit outside this block.

The remembered level is cleared by reset and is frozen while the timer is stopped. Because of this, enabling the timer can report an edge at once when the filtered pin level differs from the level that was stored before the stop. Configuration inputs are only defined while the timer is stopped.

Top module: `tmr_pin_qualifier`

## Requirements
- R1: While rst_n is low, cnt_pulse and cap_pulse are low, whatever the pin, run and select inputs are doing.
- R2: In count mode, a pin level change driven just after a clock edge and then held produces its strobe in the fourth full clock cycle after the change: two synchronizer flops, two filter samples, then the strobe.
- R3: In count mode, a pin pulse lasting one clock cycle produces no strobe. A pulse lasting two clock cycles is accepted as two edges when both edges are selected.
- R4: In capture mode the filter advances only on cycles where smp_en is high. A pin pulse too short to be seen on two consecutive strobes is rejected, and a held level is accepted.
- R5: edge_sel encoding: 2'b00 selects no edges, 2'b01 rising only, 2'b10 falling only, 2'b11 both.
- R6: With cap_mode = 0, strobes appear only on cnt_pulse. With cap_mode = 1, strobes appear only on cap_pulse.
- R7: Each accepted edge yields exactly one strobe of one system-clock cycle.
- R8: While run_en is low no strobe is produced. Re-enabling with the filtered level equal to the level stored before the stop produces no strobe.
- R9: The stored previous level resets to 0. If the pin is high after reset, enabling the timer reports a rising edge with rising or both selected, and nothing with falling only selected.
- R10: If the timer stops with the level high and is re-enabled after the level has gone low, a falling strobe is reported with falling or both selected, and none with rising only selected.
- R11: If the timer stops with the level low and is re-enabled after the level has gone high, a rising strobe is reported with rising or both selected, and none with falling only selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous external timer pin |
| smp_en | input | 1 | Prescaled sampling strobe, used in capture mode |
| run_en | input | 1 | Timer run enable |
| edge_sel | input | 2 | Edge selection (00 none, 01 rise, 10 fall, 11 both) |
| cap_mode | input | 1 | 0: count-enable use, 1: capture-trigger use |
| cnt_pulse | output | 1 | One-cycle count enable strobe |
| cap_pulse | output | 1 | One-cycle capture trigger strobe |

## Verification
The assertions assume that edge_sel and cap_mode change only while run_en is low. They also assume reset is held for at least two clock cycles, so the single-strobe and frozen-level properties start from cleared state. The stimulus reprograms the selection and mode only after dropping run_en. It always returns the pin low and lets the filter settle before stopping, so each scenario starts from a known stored level. In capture mode, smp_en is a free-running strobe one cycle in four, and pin pulses are sized against that period.

// File: rtl/tpq_pkg.sv
// Shared types for the timer pin qualifier.
package tpq_pkg;
    // Edge selection codes; bit 0 enables rising, bit 1 enables falling.
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_BOTH = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/tpq_sync.sv
// tpq_sync: multi-flop synchronizer for one asynchronous bit.
// Assumes STAGES >= 2. Resets to 0.
module tpq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    // Shift the raw pin through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d};
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/tpq_filter.sv
// tpq_filter: accepts a new level only after it is seen on SAMPLES
// consecutive strobes. The accepted level resets to 0.
// Assumes SAMPLES >= 2 and a synchronized input.
module tpq_filter #(
    parameter int SAMPLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic d,
    output logic lvl
);
    localparam int CW = (SAMPLES > 2) ? $clog2(SAMPLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SAMPLES - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    // Count strobes that see a differing level; any matching sample restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (stb) begin
            if (d != lvl_q) begin
                if (cnt_q == LAST) begin
                    lvl_q <= d;
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign lvl = lvl_q;

    // R4
    lvl_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (lvl_q != $past(lvl_q))) |-> $past(stb));
    // R3
    lvl_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (lvl_q != $past(lvl_q))) |-> ($past(d) == lvl_q));
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt_q) < SAMPLES));
endmodule

// File: rtl/tpq_edge.sv
// tpq_edge: compares the filtered level with a stored previous level
// and emits one-cycle strobes for selected edges. The stored level
// resets to 0 and updates only while running. Assumes edge_sel and
// cap_mode are stable while run_en is high.
module tpq_edge
    import tpq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       lvl,
    input  logic [1:0] edge_sel,
    input  logic       cap_mode,
    output logic       cnt_pulse,
    output logic       cap_pulse
);
    logic      prev_q;
    logic      rise, fall, hit;
    edge_sel_e sel;

    // Remember the filtered level, but only while the timer runs.
    always_ff @(posedge clk) begin
        if (!rst_n)      prev_q <= 1'b0;
        else if (run_en) prev_q <= lvl;
    end

    // Decide whether the current difference is a selected edge.
    always_comb begin
        sel  = edge_sel_e'(edge_sel);
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        unique case (sel)
            SEL_RISE: hit = rise;
            SEL_FALL: hit = fall;
            SEL_BOTH: hit = rise | fall;
            default:  hit = 1'b0;
        endcase
    end

    // Route the strobe to the count or capture output.
    always_comb begin
        cnt_pulse = run_en & hit & ~cap_mode;
        cap_pulse = run_en & hit & cap_mode;
    end

    // R8
    prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(run_en)) |-> (prev_q == $past(prev_q)));
    // R7
    cnt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_pulse |=> !cnt_pulse);
    // R7
    cap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> !cap_pulse);
endmodule

// File: rtl/tmr_pin_qualifier.sv
// tmr_pin_qualifier: input conditioning for an external timer pin.
// Synchronizes the pin, filters it on every clock (count mode) or on
// smp_en (capture mode), and emits one-cycle edge strobes.
// Assumes configuration changes only while run_en is low.
module tmr_pin_qualifier
    import tpq_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int FILT_SAMPLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_in,
    input  logic       smp_en,
    input  logic       run_en,
    input  logic [1:0] edge_sel,
    input  logic       cap_mode,
    output logic       cnt_pulse,
    output logic       cap_pulse
);
    logic pin_s;
    logic stb;
    logic lvl;

    // Pick the filter strobe: every clock for counting, prescaled for capture.
    always_comb stb = cap_mode ? smp_en : 1'b1;

    tpq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    tpq_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .d     (pin_s),
        .lvl   (lvl)
    );

    tpq_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .lvl       (lvl),
        .edge_sel  (edge_sel),
        .cap_mode  (cap_mode),
        .cnt_pulse (cnt_pulse),
        .cap_pulse (cap_pulse)
    );

    // R5
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_sel == SEL_RISE) && (cnt_pulse || cap_pulse)) |-> lvl);
    // R5
    fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_sel == SEL_FALL) && (cnt_pulse || cap_pulse)) |-> !lvl);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        (!rst_n && !$past(rst_n)) |-> !(cnt_pulse || cap_pulse));
endmodule

// File: tb/sim_tmr_pin_qualifier.sv
`timescale 1ns/1ps
module sim_tmr_pin_qualifier;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       smp_en = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       cap_mode = 1'b0;
    logic       cnt_p, cap_p;

    int n_chk = 0, n_fail = 0;
    int n_cnt = 0, n_cap = 0, run_len = 0, max_len = 0;
    int div = 0;

    localparam logic [1:0] NONE = 2'b00, RISE = 2'b01, FALL = 2'b10, BOTH = 2'b11;

    tmr_pin_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .smp_en(smp_en),
        .run_en(run_en), .edge_sel(sel), .cap_mode(cap_mode),
        .cnt_pulse(cnt_p), .cap_pulse(cap_p)
    );

    always #5 clk = ~clk;

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (cnt_p) n_cnt++;
        if (cap_p) n_cap++;
        if (cnt_p || cap_p) begin
            run_len++;
            if (run_len > max_len) max_len = run_len;
        end else begin
            run_len = 0;
        end
    end

    // Prescaled strobe: one cycle in four.
    initial forever begin
        @(posedge clk); #1;
        div = (div + 1) % 4;
        smp_en = (div == 0);
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic clr();
        n_cnt = 0; n_cap = 0; run_len = 0; max_len = 0;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic pin_lvl);
        rst_n = 1'b0; run_en = 1'b0; sel = NONE; cap_mode = 1'b0; pin = pin_lvl;
        tick(5);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_en = 1'b1; sel = BOTH; cap_mode = 1'b0;
        tick(2);
        clr();
        for (int i = 0; i < 6; i++) begin pin = ~pin; tick(3); end
        check("R1", "strobes during reset", n_cnt + n_cap, 0);
        pin = 1'b0; tick(3);
        rst_n = 1'b1; clr();
        tick(10);
        check("R1", "strobes after reset with pin low", n_cnt + n_cap, 0);
        run_en = 1'b0; tick(1);
    endtask

    task automatic t_latency();
        int first = -1;
        int seen = 0;
        sel = RISE; cap_mode = 1'b0; run_en = 1'b1;
        tick(4);
        pin = 1'b1;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (cnt_p) begin
                seen++;
                if (first < 0) first = i;
            end
        end
        check("R2", "strobe cycle after change", first, 4);
        check("R7", "strobe length", seen, 1);
        tick(1); pin = 1'b0; tick(8); run_en = 1'b0; tick(1);
    endtask

    task automatic t_glitch_count();
        sel = BOTH; cap_mode = 1'b0; run_en = 1'b1; tick(4);
        clr();
        pin = 1'b1; tick(1); pin = 1'b0; tick(8);
        check("R3", "one-cycle glitch", n_cnt, 0);
        clr();
        pin = 1'b1; tick(2); pin = 1'b0; tick(10);
        check("R3", "two-cycle pulse edges", n_cnt, 2);
        check("R6", "no capture strobe in count mode", n_cap, 0);
        run_en = 1'b0; tick(1);
    endtask

    task automatic t_capture();
        sel = RISE; cap_mode = 1'b1; run_en = 1'b1; tick(12);
        clr();
        pin = 1'b1; tick(3); pin = 1'b0; tick(16);
        check("R4", "short pulse in capture mode", n_cap, 0);
        clr();
        pin = 1'b1; tick(16); pin = 1'b0; tick(16);
        check("R4", "held level in capture mode", n_cap, 1);
        check("R6", "no count strobe in capture mode", n_cnt, 0);
        run_en = 1'b0; tick(1); cap_mode = 1'b0;
    endtask

    task automatic t_mode(input logic [1:0] s, input int exp);
        run_en = 1'b0; sel = s; cap_mode = 1'b0; tick(1);
        run_en = 1'b1; tick(4);
        clr();
        for (int i = 0; i < 3; i++) begin
            pin = 1'b1; tick(6); pin = 1'b0; tick(6);
        end
        tick(4);
        check("R5", "edge count for select code", n_cnt, exp);
        if (exp > 0) check("R7", "max strobe width", max_len, 1);
        run_en = 1'b0; tick(1);
    endtask

    task automatic t_stopped();
        run_en = 1'b0; sel = BOTH; cap_mode = 1'b0; tick(1);
        clr();
        for (int i = 0; i < 4; i++) begin pin = 1'b1; tick(6); pin = 1'b0; tick(6); end
        check("R8", "strobes while stopped", n_cnt + n_cap, 0);
        clr();
        run_en = 1'b1; tick(6);
        check("R8", "enable with unchanged level", n_cnt, 0);
        run_en = 1'b0; tick(1);
    endtask

    task automatic t_spur(input string req, input logic stop_lvl, input logic new_lvl,
                          input logic [1:0] s, input int exp);
        sel = NONE; cap_mode = 1'b0; run_en = 1'b1; pin = stop_lvl; tick(8);
        run_en = 1'b0; pin = new_lvl; tick(8);
        sel = s; clr();
        run_en = 1'b1; tick(4);
        check(req, "strobes on re-enable", n_cnt, exp);
        sel = NONE; pin = 1'b0; tick(8);
        run_en = 1'b0; tick(1);
    endtask

    task automatic t_after_reset(input logic [1:0] s, input int exp);
        do_reset(1'b1);
        tick(8);
        sel = s; clr();
        run_en = 1'b1; tick(4);
        check("R9", "enable after reset with pin high", n_cnt, exp);
        sel = NONE; pin = 1'b0; tick(8); run_en = 1'b0; tick(1);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_latency();
        t_glitch_count();
        t_capture();
        t_mode(NONE, 0);
        t_mode(RISE, 3);
        t_mode(FALL, 3);
        t_mode(BOTH, 6);
        t_stopped();
        t_spur("R10", 1'b1, 1'b0, FALL, 1);
        t_spur("R10", 1'b1, 1'b0, BOTH, 1);
        t_spur("R10", 1'b1, 1'b0, RISE, 0);
        t_spur("R11", 1'b0, 1'b1, RISE, 1);
        t_spur("R11", 1'b0, 1'b1, BOTH, 1);
        t_spur("R11", 1'b0, 1'b1, FALL, 0);
        t_after_reset(RISE, 1);
        t_after_reset(BOTH, 1);
        t_after_reset(FALL, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule